// File: doc/BRIEF.md
# In-Circuit Test Mode Controller with NAND Chain

This block is the board-test support logic of a bus interface chip. A dedicated test strobe and two mode-select inputs let a board tester arm or disarm a connectivity-test mode. The tester first holds the strobe low and sets the mode selects and an 8-bit command bus. It then raises the strobe, and the command present at that rising edge is decoded. One code turns the connectivity mode on and another turns it off. Every other code is ignored, and so is any edge where the mode selects are not in their setup state.

While the mode is on, a chain of two-input NAND gates folds a parameterized set of monitored input pins into a single observable output. A tester can then confirm each solder joint by pulling one pin low and watching that output flip. While the mode is off, the output pin carries its normal functional signal. A separate float request drops the chip's output enable so that the pins go to high impedance for bed-of-nails testing.

The strobe is asynchronous to the core clock. It passes through a synchronizer, and the command and mode selects must be held stable until the mode register updates.

Top module: `board_test_ctrl`

## Requirements
- R1: After reset, tree_mode_o is 0, tree_o follows func_i, and out_en_o is 1 while float_req_i is 0.
- R2: strobe_i passes through a two-stage synchronizer. After strobe_i goes high, tree_mode_o takes its new value on the third rising clk_i edge and is unchanged after the second.
- R3: A rising strobe with sel_a_i = 0, sel_b_i = 1 and cmd_i = 8'h02 (only bit 1 set) sets tree_mode_o to 1.
- R4: A rising strobe with sel_a_i = 0, sel_b_i = 1 and cmd_i = 8'h00 clears tree_mode_o to 0.
- R5: A rising strobe in the qualified select state with any cmd_i other than 8'h00 or 8'h02 leaves tree_mode_o unchanged.
- R6: A rising strobe with sel_a_i = 1 or sel_b_i = 0 leaves tree_mode_o unchanged, whatever the value of cmd_i.
- R7: While tree_mode_o is 1, tree_o equals the NAND of all mon_i bits. With every other monitored input high, driving any single input low flips tree_o from 0 to 1.
- R8: While tree_mode_o is 0, tree_o equals func_i for any mon_i.
- R9: out_en_o is the inverse of float_req_i in either mode, so float_req_i = 1 places the outputs in high impedance.
- R10: A change on cmd_i or the mode selects while strobe_i stays high has no effect. Only a rising strobe loads a command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| strobe_i | input | 1 | Test strobe, asynchronous; its rising edge loads a command |
| sel_a_i | input | 1 | Mode select, must be low to qualify a command |
| sel_b_i | input | 1 | Mode select, must be high to qualify a command |
| cmd_i | input | 8 | Command bus, sampled on the strobe rising edge |
| float_req_i | input | 1 | High requests high-impedance outputs |
| mon_i | input | N_MON | Monitored functional inputs feeding the NAND chain |
| func_i | input | 1 | Normal functional signal for the shared output pin |
| tree_o | output | 1 | Chain result in test mode, func_i otherwise |
| tree_mode_o | output | 1 | Current connectivity-test mode |
| out_en_o | output | 1 | Output enable for the chip's pads |

## Verification
On every cycle, the assertions check the following:
- The mode rises only after a qualified strobe edge that carried the on code.
- The mode falls only after a qualified strobe edge that carried the off code.
- The mode stays put on unqualified edges and on unknown codes.
- tree_o matches the NAND of the monitored inputs in test mode and passes func_i through otherwise.

The exact three-edge latency, the walk over every monitored pin, and the immunity to bus changes under a held-high strobe are shown only by the bench's directed scenarios.

// File: rtl/bt_pkg.sv
package bt_pkg;
  localparam int unsigned CMD_W = 8;
  typedef logic [CMD_W-1:0] cmd_t;
  localparam cmd_t CMD_TREE_ON  = 8'h02;
  localparam cmd_t CMD_TREE_OFF = 8'h00;
endpackage

// File: rtl/bt_edge_sync.sv
module bt_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sync_q[g] <= 1'b0;
      else if (g == 0) sync_q[g] <= async_i;
      else sync_q[g] <= sync_q[(g == 0) ? 0 : g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_q <= 1'b0;
    else         last_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/bt_cmd_decode.sv
module bt_cmd_decode
  import bt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_i,
  input  logic sel_a_i,
  input  logic sel_b_i,
  input  cmd_t cmd_i,
  output logic mode_o
);
  logic qual;
  logic mode_q;

  assign qual = rise_i & ~sel_a_i & sel_b_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= 1'b0;
    else if (qual) begin
      if (cmd_i == CMD_TREE_ON)       mode_q <= 1'b1;
      else if (cmd_i == CMD_TREE_OFF) mode_q <= 1'b0;
    end
  end

  assign mode_o = mode_q;

  assert_on_code_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mode_q) |-> $past(rise_i && !sel_a_i && sel_b_i && cmd_i == 8'h02));

  assert_off_code_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(mode_q) |-> $past(rise_i && !sel_a_i && sel_b_i && cmd_i == 8'h00));

  assert_unknown_code_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i && !sel_a_i && sel_b_i && cmd_i != 8'h02 && cmd_i != 8'h00) |=> $stable(mode_q));

  assert_unqualified_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rise_i || sel_a_i || !sel_b_i) |=> $stable(mode_q));
endmodule

// File: rtl/bt_nand_chain.sv
module bt_nand_chain #(
  parameter int unsigned N_IN = 16
) (
  input  logic [N_IN-1:0] in_i,
  output logic            out_o
);
  // Inverting link between NAND stages: any low input latches the chain high.
  logic [N_IN-1:0] stage;

  assign stage[0] = ~in_i[0];
  for (genvar k = 1; k < N_IN; k++) begin : g_link
    assign stage[k] = ~(~stage[k-1] & in_i[k]);
  end

  assign out_o = stage[N_IN-1];
endmodule

// File: rtl/board_test_ctrl.sv
module board_test_ctrl
  import bt_pkg::*;
#(
  parameter int unsigned N_MON       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             strobe_i,
  input  logic             sel_a_i,
  input  logic             sel_b_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             float_req_i,
  input  logic [N_MON-1:0] mon_i,
  input  logic             func_i,
  output logic             tree_o,
  output logic             tree_mode_o,
  output logic             out_en_o
);
  logic strobe_rise;
  logic mode;
  logic chain_out;

  bt_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(strobe_i),
    .rise_o (strobe_rise)
  );

  bt_cmd_decode u_dec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rise_i (strobe_rise),
    .sel_a_i(sel_a_i),
    .sel_b_i(sel_b_i),
    .cmd_i  (cmd_i),
    .mode_o (mode)
  );

  bt_nand_chain #(.N_IN(N_MON)) u_chain (
    .in_i (mon_i),
    .out_o(chain_out)
  );

  assign tree_o      = mode ? chain_out : func_i;
  assign tree_mode_o = mode;
  assign out_en_o    = ~float_req_i;

  assert_tree_nand_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode |-> (tree_o == ~(&mon_i)));

  assert_func_pass_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode |-> (tree_o == func_i));
endmodule

// File: tb/sim_board_test_ctrl.sv
`timescale 1ns/1ps
module sim_board_test_ctrl;
  localparam int N = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         strobe = 1'b0, sel_a = 1'b0, sel_b = 1'b1, flt = 1'b0, func = 1'b0;
  logic [7:0]   cmd = 8'h00;
  logic [N-1:0] mon = '1;
  logic         tree, mode, oen;
  int           n_chk = 0, n_bad = 0;
  bit           done = 0;

  always #2.5 clk = ~clk;

  board_test_ctrl #(.N_MON(N)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .strobe_i(strobe), .sel_a_i(sel_a), .sel_b_i(sel_b),
    .cmd_i(cmd), .float_req_i(flt), .mon_i(mon), .func_i(func),
    .tree_o(tree), .tree_mode_o(mode), .out_en_o(oen)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_neg(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic load(logic [7:0] c, logic a, logic b);
    @(negedge clk);
    strobe = 1'b0; sel_a = a; sel_b = b; cmd = c;
    wait_neg(4);
    strobe = 1'b1;
    wait_neg(4);
    strobe = 1'b0;
    wait_neg(4);
  endtask

  task automatic t_reset;
    func = 1'b1; #1;
    chk("R1 mode", mode, 0);
    chk("R1 oen", oen, 1);
    chk("R1 tree", tree, 1);
    func = 1'b0; #1;
    chk("R1 tree", tree, 0);
  endtask

  task automatic t_latency;
    @(negedge clk);
    sel_a = 1'b0; sel_b = 1'b1; cmd = 8'h02; strobe = 1'b0;
    wait_neg(4);
    strobe = 1'b1;
    wait_neg(2);
    chk("R2 after 2 edges", mode, 0);
    wait_neg(1);
    chk("R2 after 3 edges", mode, 1);
    strobe = 1'b0;
    wait_neg(4);
    chk("R3 on", mode, 1);
  endtask

  task automatic t_off_on;
    load(8'h00, 1'b0, 1'b1);
    chk("R4 off", mode, 0);
    load(8'h02, 1'b0, 1'b1);
    chk("R3 on again", mode, 1);
  endtask

  task automatic t_unknown;
    load(8'h01, 1'b0, 1'b1); chk("R5 0x01 on", mode, 1);
    load(8'h82, 1'b0, 1'b1); chk("R5 0x82 on", mode, 1);
    load(8'h00, 1'b0, 1'b1); chk("R4 off", mode, 0);
    load(8'h03, 1'b0, 1'b1); chk("R5 0x03 off", mode, 0);
    load(8'hFF, 1'b0, 1'b1); chk("R5 0xFF off", mode, 0);
  endtask

  task automatic t_unqualified;
    load(8'h02, 1'b1, 1'b1); chk("R6 a=1", mode, 0);
    load(8'h02, 1'b0, 1'b0); chk("R6 b=0", mode, 0);
    load(8'h02, 1'b1, 1'b0); chk("R6 a=1 b=0", mode, 0);
    load(8'h02, 1'b0, 1'b1); chk("R3 on", mode, 1);
    load(8'h00, 1'b1, 1'b1); chk("R6 off a=1", mode, 1);
  endtask

  task automatic t_held;
    @(negedge clk);
    strobe = 1'b1; sel_a = 1'b0; sel_b = 1'b1; cmd = 8'h02;
    wait_neg(5);
    cmd = 8'h00;
    wait_neg(6);
    chk("R10 held high", mode, 1);
    strobe = 1'b0;
    wait_neg(6);
    chk("R10 after fall", mode, 1);
  endtask

  task automatic t_tree;
    mon = '1; #1;
    chk("R7 all high", tree, 0);
    for (int j = 0; j < N; j++) begin
      mon = '1; mon[j] = 1'b0; #1;
      chk($sformatf("R7 pin %0d low", j), tree, 1);
      mon[j] = 1'b1; #1;
      chk($sformatf("R7 pin %0d restored", j), tree, 0);
    end
    mon = '0; #1;                 chk("R7 all low", tree, 1);
    mon = 16'hA5F0; #1;           chk("R7 mixed", tree, 1);
    func = 1'b0; mon = '1; #1;    chk("R7 ignores func", tree, 0);
    mon = '1;
  endtask

  task automatic t_func;
    load(8'h00, 1'b0, 1'b1);
    chk("R4 off", mode, 0);
    mon = 16'h1234; func = 1'b1; #1; chk("R8 func 1", tree, 1);
    mon = '1;       func = 1'b0; #1; chk("R8 func 0", tree, 0);
    mon = '0;       func = 1'b1; #1; chk("R8 func 1 low mon", tree, 1);
    mon = '1;
  endtask

  task automatic t_float;
    flt = 1'b1; #1; chk("R9 float off-mode", oen, 0);
    flt = 1'b0; #1; chk("R9 release", oen, 1);
    load(8'h02, 1'b0, 1'b1);
    flt = 1'b1; #1; chk("R9 float on-mode", oen, 0);
    chk("R9 mode kept", mode, 1);
    flt = 1'b0; #1; chk("R9 release on-mode", oen, 1);
  endtask

  initial begin
    wait_neg(3);
    t_reset;
    rst_n = 1'b1;
    wait_neg(2);
    t_reset;
    t_latency;
    t_off_on;
    t_unknown;
    t_unqualified;
    t_held;
    t_tree;
    t_func;
    t_float;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule